// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block translates 44-bit virtual addresses into 41-bit physical addresses through a 64-entry, fully associative table. Each entry holds one of four page sizes, so one entry can map a region anywhere from 8 KB to 4 MB. A one-entry front cache (the micro entry) is consulted first. When it hits, the answer comes back one cycle after the request. When it misses, the block searches the main table in a second cycle and copies the matching entry into the micro entry. A miss in the main table produces a one-cycle miss response with no translation. Software then installs the mapping through the write port.

The write port places each new entry into a slot picked by the block. The lowest-numbered empty slot is used first. Once the table is full, a round-robin pointer walks over the entries and skips any that were installed as locked. If every entry is locked, the write is discarded and an error pulse is returned. Every write request flushes the micro entry.

Control is a two-state machine. `ST_IDLE` accepts lookups and answers micro hits. `ST_MAIN` is the one-cycle main-table search. The transition IDLE→MAIN fires on an accepted lookup that misses the micro entry. MAIN→IDLE is taken unconditionally on the next edge. IDLE→IDLE covers all other cycles.

Top module: `xlat_tlb`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_miss` and `wr_err` are low, `lk_ready` is high, and the table holds no valid entries, so the first lookup misses.
- R2: A lookup accepted (`lk_valid` and `lk_ready`) while the micro entry matches gives `rsp_valid` high with `rsp_miss` low on the next rising edge.
- R3: A lookup that misses the micro entry but hits the main table responds exactly one cycle later than a micro hit, on the second edge after acceptance. `lk_ready` is low for that one intervening cycle. The micro entry is then loaded, so a repeat lookup in the same page answers in one cycle.
- R4: A lookup that misses both the micro entry and the main table responds on the second edge with `rsp_valid` and `rsp_miss` high and `rsp_paddr` equal to zero.
- R5: Page-size code 0 selects 8 KB pages (13 offset bits), code 1 selects 16 KB (14), code 2 selects 512 KB (19) and code 3 selects 4 MB (22). A lookup matches an entry when virtual address bits [43:offset] equal those of the address that was written.
- R6: The translated address takes bits [40:offset] from the physical address that was written and bits [offset-1:0] from the lookup address.
- R7: When several valid entries match, the entry with the lowest slot index supplies the translation.
- R8: A write goes into the lowest-index invalid slot while any slot is invalid.
- R9: With all slots valid, a write replaces the first unlocked slot at or after a round-robin pointer. The pointer is 0 after reset and moves to one past each slot replaced this way. A locked slot is never replaced.
- R10: A write made while all 64 slots are locked changes nothing, and `wr_err` is high for exactly the following cycle.
- R11: Any write request invalidates the micro entry, so the next lookup takes the two-cycle path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 44 | Virtual address to translate |
| lk_ready | output | 1 | High when a lookup can be accepted |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_miss | output | 1 | Response carries no translation |
| rsp_paddr | output | 41 | Translated physical address |
| wr_en | input | 1 | Install-entry request |
| wr_vaddr | input | 44 | Virtual address of the new mapping |
| wr_paddr | input | 41 | Physical address of the new mapping |
| wr_size | input | 2 | Page-size code of the new mapping |
| wr_lock | input | 1 | Protect the new entry from replacement |
| wr_err | output | 1 | Write dropped because every slot is locked |

## Verification
The assertions check the following on every cycle:
- the search state always returns to idle after one cycle, together with a response;
- a micro hit always answers on the next edge;
- miss responses carry a zero address;
- the micro entry is empty after any write;
- the victim picker never selects a locked slot and always prefers an empty one.

Only the bench's scenarios can show the rest:
- the translation values for each page size;
- priority between overlapping entries;
- the exact round-robin order once the table is full;
- the case where every slot is locked and the write is dropped.

The bench checks these against a model of the table.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int unsigned MIN_OFS = 13;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_16K  = 2'd1,
        PG_512K = 2'd2,
        PG_4M   = 2'd3
    } pg_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MAIN = 1'b1
    } xlat_state_e;

    // number of untranslated offset bits for a page-size code
    function automatic int unsigned pg_ofs(input logic [1:0] code);
        int unsigned r;
        unique case (pg_size_e'(code))
            PG_8K:   r = 13;
            PG_16K:  r = 14;
            PG_512K: r = 19;
            PG_4M:   r = 22;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xlat_array.sv
module xlat_array
    import xlat_pkg::*;
#(
    parameter int unsigned VA_W    = 44,
    parameter int unsigned PA_W    = 41,
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = VA_W - MIN_OFS,
    localparam int unsigned FRM_W  = PA_W - MIN_OFS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_go,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [FRM_W-1:0]   wr_frame,
    input  logic [1:0]         wr_size,
    input  logic               wr_lock,
    input  logic [TAG_W-1:0]   look_tag,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_idx,
    output logic [FRM_W-1:0]   hit_frame,
    output logic [1:0]         hit_size,
    output logic [ENTRIES-1:0] vld_vec,
    output logic [ENTRIES-1:0] lck_vec
);

    logic [TAG_W-1:0]   tag_q   [ENTRIES];
    logic [FRM_W-1:0]   frame_q [ENTRIES];
    logic [1:0]         size_q  [ENTRIES];
    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] lck_q;
    logic [ENTRIES-1:0] match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            lck_q <= '0;
        end else if (wr_go) begin
            vld_q[wr_idx] <= 1'b1;
            lck_q[wr_idx] <= wr_lock;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            tag_q[wr_idx]   <= wr_tag;
            frame_q[wr_idx] <= wr_frame;
            size_q[wr_idx]  <= wr_size;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [TAG_W-1:0] cmp_mask;
        assign cmp_mask = {TAG_W{1'b1}} << (pg_ofs(size_q[g]) - MIN_OFS);
        assign match[g] = vld_q[g] && (((look_tag ^ tag_q[g]) & cmp_mask) == '0);

        assert_lock_only_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
            lck_q[g] |-> vld_q[g]);
    end

    // lowest index wins: scan downward so the last assignment is the smallest
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit       = |match;
    assign hit_frame = frame_q[hit_idx];
    assign hit_size  = size_q[hit_idx];
    assign vld_vec   = vld_q;
    assign lck_vec   = lck_q;

    assert_write_sets_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld_vec,
    input  logic [ENTRIES-1:0] lck_vec,
    input  logic               commit,
    output logic [IDX_W-1:0]   vic_idx,
    output logic               vic_ok
);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_idx;
    logic             any_free;
    logic             rr_found;

    assign any_free = ~&vld_vec;

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) free_idx = IDX_W'(i);
        end
    end

    always_comb begin
        rr_found = 1'b0;
        rr_idx   = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (!rr_found && !lck_vec[(int'(ptr_q) + k) % ENTRIES]) begin
                rr_found = 1'b1;
                rr_idx   = IDX_W'((int'(ptr_q) + k) % ENTRIES);
            end
        end
    end

    assign vic_idx = any_free ? free_idx : rr_idx;
    assign vic_ok  = any_free || rr_found;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (commit && !any_free) begin
            ptr_q <= (int'(rr_idx) == ENTRIES - 1) ? '0 : rr_idx + 1'b1;
        end
    end

    assert_victim_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vic_ok |-> !lck_vec[vic_idx]);

    assert_prefer_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(&vld_vec) |-> (vic_ok && !vld_vec[vic_idx]));

    assert_all_locked_no_victim_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&lck_vec) |-> !vic_ok);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int unsigned VA_W    = 44,
    parameter int unsigned PA_W    = 41,
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned TAG_W  = VA_W - MIN_OFS,
    localparam int unsigned FRM_W  = PA_W - MIN_OFS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [VA_W-1:0] lk_vaddr,
    output logic            lk_ready,
    output logic            rsp_valid,
    output logic            rsp_miss,
    output logic [PA_W-1:0] rsp_paddr,
    input  logic            wr_en,
    input  logic [VA_W-1:0] wr_vaddr,
    input  logic [PA_W-1:0] wr_paddr,
    input  logic [1:0]      wr_size,
    input  logic            wr_lock,
    output logic            wr_err
);

    xlat_state_e      state_q, state_d;
    logic [VA_W-1:0]  req_va_q;
    logic             u_vld;
    logic [TAG_W-1:0] u_tag;
    logic [FRM_W-1:0] u_frame;
    logic [1:0]       u_size;
    logic             u_hit;
    logic [TAG_W-1:0] u_mask;

    logic             a_hit;
    logic [IDX_W-1:0] a_idx;
    logic [FRM_W-1:0] a_frame;
    logic [1:0]       a_size;
    logic [ENTRIES-1:0] vld_vec, lck_vec;
    logic [IDX_W-1:0] vic_idx;
    logic             vic_ok;
    logic             wr_go;
    logic             unused_low_bits;

    assign unused_low_bits = ^{wr_vaddr[MIN_OFS-1:0], wr_paddr[MIN_OFS-1:0], a_idx};

    function automatic logic [PA_W-1:0] build_pa(input logic [FRM_W-1:0] frm,
                                                 input logic [1:0] sz,
                                                 input logic [VA_W-1:0] va);
        logic [PA_W-1:0] low_mask;
        low_mask = (PA_W'(1) << pg_ofs(sz)) - PA_W'(1);
        return ({frm, {MIN_OFS{1'b0}}} & ~low_mask) | (va[PA_W-1:0] & low_mask);
    endfunction

    assign wr_go    = wr_en && vic_ok;
    assign u_mask   = {TAG_W{1'b1}} << (pg_ofs(u_size) - MIN_OFS);
    assign u_hit    = u_vld && (((lk_vaddr[VA_W-1:MIN_OFS] ^ u_tag) & u_mask) == '0);
    assign lk_ready = (state_q == ST_IDLE);

    xlat_array #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENTRIES)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .wr_idx    (vic_idx),
        .wr_tag    (wr_vaddr[VA_W-1:MIN_OFS]),
        .wr_frame  (wr_paddr[PA_W-1:MIN_OFS]),
        .wr_size   (wr_size),
        .wr_lock   (wr_lock),
        .look_tag  (req_va_q[VA_W-1:MIN_OFS]),
        .hit       (a_hit),
        .hit_idx   (a_idx),
        .hit_frame (a_frame),
        .hit_size  (a_size),
        .vld_vec   (vld_vec),
        .lck_vec   (lck_vec)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_vec (vld_vec),
        .lck_vec (lck_vec),
        .commit  (wr_go),
        .vic_idx (vic_idx),
        .vic_ok  (vic_ok)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (lk_valid && !u_hit) state_d = ST_MAIN;
            ST_MAIN: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_paddr <= '0;
            req_va_q  <= '0;
            wr_err    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_miss  <= 1'b0;
            wr_err    <= wr_en && !vic_ok;
            unique case (state_q)
                ST_IDLE: begin
                    if (lk_valid && u_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_paddr <= build_pa(u_frame, u_size, lk_vaddr);
                    end else if (lk_valid) begin
                        req_va_q <= lk_vaddr;
                    end
                end
                ST_MAIN: begin
                    rsp_valid <= 1'b1;
                    rsp_miss  <= !a_hit;
                    rsp_paddr <= a_hit ? build_pa(a_frame, a_size, req_va_q) : '0;
                end
            endcase
        end
    end

    // micro entry: flushed by any write, refilled from a main-table hit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_vld <= 1'b0;
        end else if (wr_en) begin
            u_vld <= 1'b0;
        end else if (state_q == ST_MAIN && a_hit) begin
            u_vld <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (state_q == ST_MAIN && a_hit && !wr_en) begin
            u_tag   <= req_va_q[VA_W-1:MIN_OFS];
            u_frame <= a_frame;
            u_size  <= a_size;
        end
    end

    assert_search_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN) |=> (state_q == ST_IDLE && rsp_valid));

    assert_micro_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && u_hit) |=> (rsp_valid && !rsp_miss));

    assert_miss_no_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_valid && rsp_paddr == '0));

    assert_write_flushes_micro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !u_vld);

    assert_err_after_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));

endmodule

// File: tb/xlat_tlb_test.sv
module xlat_tlb_test;

    localparam int CLK_PERIOD = 10;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_valid;
    logic [43:0] lk_vaddr;
    logic        lk_ready;
    logic        rsp_valid;
    logic        rsp_miss;
    logic [40:0] rsp_paddr;
    logic        wr_en;
    logic [43:0] wr_vaddr;
    logic [40:0] wr_paddr;
    logic [1:0]  wr_size;
    logic        wr_lock;
    logic        wr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model
    bit          m_val  [N];
    bit          m_lock [N];
    logic [1:0]  m_size [N];
    logic [43:0] m_va   [N];
    logic [40:0] m_pa   [N];
    int          m_ptr;
    bit          m_uval;
    int          m_uidx;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_tlb uut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_ready(lk_ready), .rsp_valid(rsp_valid), .rsp_miss(rsp_miss),
        .rsp_paddr(rsp_paddr), .wr_en(wr_en), .wr_vaddr(wr_vaddr),
        .wr_paddr(wr_paddr), .wr_size(wr_size), .wr_lock(wr_lock), .wr_err(wr_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ofs(input logic [1:0] sz);
        case (sz)
            2'd0: return 13;
            2'd1: return 14;
            2'd2: return 19;
            default: return 22;
        endcase
    endfunction

    function automatic bit hits(input int i, input logic [43:0] va);
        int o = ofs(m_size[i]);
        return m_val[i] && ((va >> o) == (m_va[i] >> o));
    endfunction

    function automatic logic [40:0] xlat(input int i, input logic [43:0] va);
        logic [40:0] msk = (41'd1 << ofs(m_size[i])) - 41'd1;
        return (m_pa[i] & ~msk) | (va[40:0] & msk);
    endfunction

    function automatic int find(input logic [43:0] va);
        for (int i = 0; i < N; i++) if (hits(i, va)) return i;
        return -1;
    endfunction

    function automatic int pick_victim();
        for (int i = 0; i < N; i++) if (!m_val[i]) return i;
        for (int k = 0; k < N; k++) if (!m_lock[(m_ptr + k) % N]) return (m_ptr + k) % N;
        return -1;
    endfunction

    function automatic logic [43:0] rnd_va();
        return {$urandom, $urandom};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; lk_valid = 1'b0; lk_vaddr = '0;
        wr_en = 1'b0; wr_vaddr = '0; wr_paddr = '0; wr_size = '0; wr_lock = 1'b0;
        for (int i = 0; i < N; i++) begin m_val[i] = 0; m_lock[i] = 0; end
        m_ptr = 0; m_uval = 0; m_uidx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [43:0] va, input logic [40:0] pa,
                            input logic [1:0] sz, input bit lk, input string req);
        int v;
        bit any_free;
        any_free = 0;
        for (int i = 0; i < N; i++) if (!m_val[i]) any_free = 1;
        v = pick_victim();
        wr_en = 1'b1; wr_vaddr = va; wr_paddr = pa; wr_size = sz; wr_lock = lk;
        @(negedge clk);
        wr_en = 1'b0;
        chk(wr_err == (v < 0), req, "wr_err after write", 64'(wr_err), 64'(v < 0));
        if (v >= 0) begin
            m_val[v] = 1; m_lock[v] = lk; m_size[v] = sz; m_va[v] = va; m_pa[v] = pa;
            if (!any_free) m_ptr = (v + 1) % N;
        end
        m_uval = 0;
    endtask

    task automatic do_lookup(input logic [43:0] va, input string req);
        int lat, exp_lat, idx;
        bit exp_miss;
        logic [40:0] exp_pa;
        chk(lk_ready == 1'b1, req, "lk_ready before lookup", 64'(lk_ready), 64'd1);
        if (m_uval && hits(m_uidx, va)) begin
            exp_lat = 1; exp_miss = 0; exp_pa = xlat(m_uidx, va);
        end else begin
            exp_lat = 2;
            idx = find(va);
            exp_miss = (idx < 0);
            exp_pa = (idx < 0) ? '0 : xlat(idx, va);
            if (idx >= 0) begin m_uval = 1; m_uidx = idx; end
        end
        lk_valid = 1'b1; lk_vaddr = va;
        @(negedge clk);
        lk_valid = 1'b0;
        lat = 1;
        if (!rsp_valid) begin
            chk(lk_ready == 1'b0, req, "lk_ready during search", 64'(lk_ready), 64'd0);
            @(negedge clk);
            lat = 2;
        end
        chk(rsp_valid == 1'b1, req, "response present", 64'(rsp_valid), 64'd1);
        chk(lat == exp_lat, req, "latency", 64'(lat), 64'(exp_lat));
        chk(rsp_miss == exp_miss, req, "miss flag", 64'(rsp_miss), 64'(exp_miss));
        chk(rsp_paddr == exp_pa, req, "paddr", 64'(rsp_paddr), 64'(exp_pa));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [43:0] base;
        void'($urandom(32'h5eed_7a1b));
        do_reset();

        // R1: reset state
        chk(!rsp_valid && !rsp_miss && !wr_err, "R1", "outputs after reset",
            64'({rsp_valid, rsp_miss, wr_err}), 64'd0);
        chk(lk_ready, "R1", "lk_ready after reset", 64'(lk_ready), 64'd1);
        do_lookup(44'h123_4567_89ab, "R1");

        // R4: miss returns zero address
        do_lookup(44'h0ff_0000_0000, "R4");

        // R3 then R2, R6 on an 8 KB page
        do_write(44'h0a0_0000_2000, 41'h1_2345_6000, 2'd0, 0, "R8");
        do_lookup(44'h0a0_0000_2123, "R3");
        do_lookup(44'h0a0_0000_3ff0, "R2");
        do_lookup(44'h0a0_0000_4000, "R5");

        // R5/R6 each page size: max offset hits, bit at offset boundary misses
        for (int s = 0; s < 4; s++) begin
            base = 44'h300_0000_0000 + (44'(s) << 32);
            do_write(base, 41'h0aa_aaaa_aaaa + (41'(s) << 30), 2'(s), 0, "R5");
            do_lookup(base | ((44'd1 << ofs(2'(s))) - 44'd1), "R6");
            do_lookup(base | (44'd1 << ofs(2'(s))), "R5");
        end

        // R7: overlapping 4 MB and 8 KB entries; lower index (4 MB) wins
        do_reset();
        do_write(44'h7c0_0040_0000, 41'h0_1000_0000, 2'd3, 0, "R8");
        do_write(44'h7c0_0041_2000, 41'h1_ffff_e000, 2'd0, 0, "R8");
        do_lookup(44'h7c0_0041_2abc, "R7");
        chk(rsp_paddr == 41'h0_1001_2abc, "R7", "lowest index translation",
            64'(rsp_paddr), 64'h0_1001_2abc);

        // R11: write flushes micro entry
        do_lookup(44'h7c0_0041_2abd, "R2");
        do_write(44'h555_5555_4000, 41'h0_0000_8000, 2'd1, 0, "R11");
        do_lookup(44'h7c0_0041_2abe, "R11");

        // R9: full table, slots 0 and 1 locked
        do_reset();
        for (int i = 0; i < N; i++)
            do_write(44'h100_0000_0000 + (44'(i) << 22), 41'(i) << 22, 2'd0, i < 2, "R8");
        do_write(44'h200_0000_0000, 41'h1_0000_0000, 2'd2, 0, "R9");
        do_lookup(44'h100_0000_0000 + (44'd2 << 22), "R9");
        chk(rsp_miss, "R9", "slot 2 replaced", 64'(rsp_miss), 64'd1);
        do_lookup(44'h100_0000_0000, "R9");
        chk(!rsp_miss, "R9", "locked slot 0 kept", 64'(rsp_miss), 64'd0);
        do_lookup(44'h200_0000_1234, "R9");
        do_write(44'h201_0000_0000, 41'h1_0100_0000, 2'd2, 0, "R9");
        do_lookup(44'h100_0000_0000 + (44'd3 << 22), "R9");

        // R10: all locked
        do_reset();
        for (int i = 0; i < N; i++)
            do_write(44'h400_0000_0000 + (44'(i) << 22), 41'(i) << 24, 2'd1, 1, "R10");
        do_write(44'h600_0000_0000, 41'h1_5555_4000, 2'd0, 0, "R10");
        @(negedge clk);
        chk(!wr_err, "R10", "wr_err single cycle", 64'(wr_err), 64'd0);
        do_lookup(44'h600_0000_0010, "R10");
        do_lookup(44'h400_0000_0000 + (44'd63 << 22) + 44'h3abc, "R10");

        // random mix checked against the model
        do_reset();
        for (int it = 0; it < 400; it++) begin
            int lkd = 0;
            for (int i = 0; i < N; i++) if (m_lock[i]) lkd++;
            if ($urandom_range(99) < 35) begin
                do_write(rnd_va(), 41'({$urandom, $urandom}), 2'($urandom_range(3)),
                         (lkd < 40) && ($urandom_range(15) == 0), "R9");
            end else begin
                int pick = $urandom_range(N - 1);
                if (m_val[pick] && $urandom_range(9) < 7)
                    do_lookup(m_va[pick] ^ 44'($urandom_range(4194303)), "R6");
                else
                    do_lookup(rnd_va(), "R4");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule